// File: doc/BRIEF.md
# Wake-on-LAN Power Management Controller

This block holds the control and status logic for remote wake-up in the receive path of an Ethernet MAC. Software programs one 32-bit register over a simple register bus. The bus has a write strobe, a read strobe, write data and read data. Read data is combinational and always shows the current register contents. Software enables wake sources, arms power-down mode and then waits for an interrupt.

The receive side sends single-cycle event pulses into the block:
- a magic packet was detected;
- a wake-up frame pattern matched;
- a unicast frame passed destination address filtering.

While power-down is armed, the block asserts a drop-all-frames output. An enabled wake event does three things: it records which source caused the wake, it disarms power-down and it raises the power management interrupt.

The block also keeps a 3-bit pointer into the eight wake-up filter registers. The pointer steps on each filter port access, and software can reset it through a self-clearing register bit.

Top module: `wol_pm_ctrl`

## Requirements
- R1: After reset the register reads 0, the filter pointer is 0, and `drop_frames` and `pm_irq` are low.
- R2: Bits 30:10, 8:7 and 4:3 always read 0, and writes to them have no effect.
- R3: Writing 1 to bit 31 makes bit 31 read 1 for exactly one cycle. It then clears by itself, and in that same cycle the filter pointer returns to 0.
- R4: Each cycle with `filt_access` high advances the filter pointer by one, wrapping from 7 to 0. A pending pointer reset (bit 31 set) wins over an advance in the same cycle.
- R5: Bit 0 (power-down), bit 1 (magic enable), bit 2 (wake-frame enable) and bit 9 (global unicast) are written directly and read back. `drop_frames` follows bit 0.
- R6: While bit 0 and bit 1 are set, an `ev_magic` pulse sets status bit 5 and clears bit 0 on the next clock edge.
- R7: While bit 0 and bit 2 are set, an `ev_wake_frame` pulse sets status bit 6 and clears bit 0 on the next clock edge.
- R8: A unicast pulse (`ev_ucast_pass`) counts as a wake-up frame as described in R7 only when bit 9 is set. Otherwise it has no effect.
- R9: An event whose enable bit is clear, and any event while bit 0 is clear, changes no register bit and does not raise `pm_irq`.
- R10: A register read clears bits 5 and 6 on the following edge. If a read coincides with a new wake event, the read returns the old value and the new status bit stays set. Writes do not change bits 5 and 6.
- R11: `pm_irq` is high exactly while bit 5 or bit 6 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears status bits) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register contents |
| ev_magic | input | 1 | Magic packet detected pulse |
| ev_wake_frame | input | 1 | Wake-up pattern matched pulse |
| ev_ucast_pass | input | 1 | Unicast frame passed address filter pulse |
| filt_access | input | 1 | Access to the filter register port; advances the pointer |
| drop_frames | output | 1 | Drop every received frame (power-down active) |
| pm_irq | output | 1 | Power management interrupt |
| filt_ptr | output | 3 | Wake-up filter register pointer |

## Verification
The assertions check the following on every cycle:
- the one-cycle life of the pointer reset bit and the pointer returning to zero after it;
- the pointer stepping with wrap;
- reserved bits reading zero;
- no interrupt rising while power-down is off;
- a read with power-down off clearing the interrupt;
- an armed, enabled magic event both disarming power-down and raising its flag.

Only the bench scenarios show the rest:
- the exact register values read back;
- global unicast qualifying a unicast frame, and the same frame being ignored without it;
- a disabled source being ignored;
- the read that collides with an event returning the old value while the flag survives;
- write attempts to status bits being ignored.

// File: rtl/wol_pkg.sv
package wol_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned BIT_PD     = 0;
  localparam int unsigned BIT_MP_EN  = 1;
  localparam int unsigned BIT_WF_EN  = 2;
  localparam int unsigned BIT_MP_STS = 5;
  localparam int unsigned BIT_WF_STS = 6;
  localparam int unsigned BIT_GUCAST = 9;
  localparam int unsigned BIT_PRST   = 31;
  localparam int unsigned NUM_SRC    = 2;
  localparam int unsigned SRC_MAGIC  = 0;
  localparam int unsigned SRC_WFRAME = 1;

  typedef struct packed {
    logic gucast;
    logic wf_en;
    logic mp_en;
    logic pd;
    logic prst;
  } wol_ctrl_t;
endpackage

// File: rtl/wol_ctrl_reg.sv
module wol_ctrl_reg
  import wol_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             hw_wake,
  output wol_ctrl_t        ctrl
);
  wol_ctrl_t ctrl_q, ctrl_d;
  logic      cfg_en;

  assign cfg_en = wr_en;

  always_comb begin
    ctrl_d = ctrl_q;
    // pointer reset request lives exactly one cycle
    ctrl_d.prst = wr_en & wdata[BIT_PRST];
    if (cfg_en) begin
      ctrl_d.gucast = wdata[BIT_GUCAST];
      ctrl_d.wf_en  = wdata[BIT_WF_EN];
      ctrl_d.mp_en  = wdata[BIT_MP_EN];
      ctrl_d.pd     = wdata[BIT_PD];
    end
    // a qualified wake event leaves power-down regardless of a write
    if (hw_wake) ctrl_d.pd = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/wol_event_unit.sv
module wol_event_unit
  import wol_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  wol_ctrl_t          ctrl,
  input  logic               ev_magic,
  input  logic               ev_wake_frame,
  input  logic               ev_ucast_pass,
  input  logic               rd_clr,
  output logic               hw_wake,
  output logic [NUM_SRC-1:0] sts
);
  logic [NUM_SRC-1:0] hit;
  logic [NUM_SRC-1:0] sts_q, sts_d;

  always_comb begin
    hit             = '0;
    hit[SRC_MAGIC]  = ctrl.pd & ctrl.mp_en & ev_magic;
    hit[SRC_WFRAME] = ctrl.pd & ctrl.wf_en &
                      (ev_wake_frame | (ctrl.gucast & ev_ucast_pass));
  end

  assign hw_wake = |hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    always_comb begin
      sts_d[g] = sts_q[g];
      if (rd_clr) sts_d[g] = 1'b0;
      if (hit[g]) sts_d[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q[g] <= 1'b0;
      else        sts_q[g] <= sts_d[g];
    end
  end

  assign sts = sts_q;
endmodule

// File: rtl/wol_filt_ptr.sv
module wol_filt_ptr #(
  parameter int unsigned NUM_FILT = 8,
  localparam int unsigned PTR_W   = $clog2(NUM_FILT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_req,
  input  logic             advance,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_FILT - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  assign ptr_en = rst_req | advance;

  always_comb begin
    ptr_d = ptr_q;
    if (rst_req)             ptr_d = '0;
    else if (ptr_q == LAST)  ptr_d = '0;
    else                     ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/wol_pm_ctrl.sv
module wol_pm_ctrl
  import wol_pkg::*;
#(
  parameter int unsigned NUM_FILT = 8,
  localparam int unsigned PTR_W   = $clog2(NUM_FILT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ev_magic,
  input  logic             ev_wake_frame,
  input  logic             ev_ucast_pass,
  input  logic             filt_access,
  output logic             drop_frames,
  output logic             pm_irq,
  output logic [PTR_W-1:0] filt_ptr
);
  wol_ctrl_t          ctrl;
  logic               hw_wake;
  logic [NUM_SRC-1:0] sts;

  wol_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_we),
    .wdata   (reg_wdata),
    .hw_wake (hw_wake),
    .ctrl    (ctrl)
  );

  wol_event_unit u_evt (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl          (ctrl),
    .ev_magic      (ev_magic),
    .ev_wake_frame (ev_wake_frame),
    .ev_ucast_pass (ev_ucast_pass),
    .rd_clr        (reg_re),
    .hw_wake       (hw_wake),
    .sts           (sts)
  );

  wol_filt_ptr #(.NUM_FILT(NUM_FILT)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_req (ctrl.prst),
    .advance (filt_access),
    .ptr     (filt_ptr)
  );

  always_comb begin
    reg_rdata             = '0;
    reg_rdata[BIT_PRST]   = ctrl.prst;
    reg_rdata[BIT_GUCAST] = ctrl.gucast;
    reg_rdata[BIT_WF_STS] = sts[SRC_WFRAME];
    reg_rdata[BIT_MP_STS] = sts[SRC_MAGIC];
    reg_rdata[BIT_WF_EN]  = ctrl.wf_en;
    reg_rdata[BIT_MP_EN]  = ctrl.mp_en;
    reg_rdata[BIT_PD]     = ctrl.pd;
  end

  assign drop_frames = ctrl.pd;
  assign pm_irq      = |sts;
endmodule

// File: rtl/wol_pm_ctrl_chk.sv
module wol_pm_ctrl_chk #(
  parameter int unsigned PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic             reg_re,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             ev_magic,
  input logic             filt_access,
  input logic             drop_frames,
  input logic             pm_irq,
  input logic [PTR_W-1:0] filt_ptr
);
  localparam logic [31:0] RSVD_MASK = 32'h7FFF_FD98;

  p_prst_selfclear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[31] && !(reg_we && reg_wdata[31])) |=> !reg_rdata[31]);

  p_prst_zeroes_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31] |=> (filt_ptr == '0));

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_access && !reg_rdata[31]) |=> (filt_ptr == PTR_W'($past(filt_ptr) + 1'b1)));

  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!filt_access && !reg_rdata[31]) |=> $stable(filt_ptr));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & RSVD_MASK) == 32'h0);

  p_magic_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_frames && reg_rdata[1] && ev_magic) |=> (!drop_frames && reg_rdata[5]));

  p_no_irq_awake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !drop_frames |=> !$rose(pm_irq));

  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && !drop_frames) |=> !pm_irq);

  p_irq_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pm_irq == (reg_rdata[5] | reg_rdata[6]));
endmodule

bind wol_pm_ctrl wol_pm_ctrl_chk #(.PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_re      (reg_re),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .ev_magic    (ev_magic),
  .filt_access (filt_access),
  .drop_frames (drop_frames),
  .pm_irq      (pm_irq),
  .filt_ptr    (filt_ptr)
);

// File: tb/tb_wol_pm_ctrl.sv
`timescale 1ns/1ps
module tb_wol_pm_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_magic = 1'b0, ev_wake_frame = 1'b0, ev_ucast_pass = 1'b0;
  logic        filt_access = 1'b0;
  logic        drop_frames, pm_irq;
  logic [2:0]  filt_ptr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wol_pm_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_magic(ev_magic),
    .ev_wake_frame(ev_wake_frame), .ev_ucast_pass(ev_ucast_pass),
    .filt_access(filt_access), .drop_frames(drop_frames), .pm_irq(pm_irq),
    .filt_ptr(filt_ptr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input logic [31:0] exp);
    #1 chk(reg_rdata === exp, req, reg_rdata, exp);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input string req, input logic [31:0] exp);
    @(negedge clk); reg_re = 1'b1;
    #1 chk(reg_rdata === exp, req, reg_rdata, exp);
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic pulse(input bit mg, input bit wf, input bit uc);
    @(negedge clk); ev_magic = mg; ev_wake_frame = wf; ev_ucast_pass = uc;
    @(negedge clk); ev_magic = 1'b0; ev_wake_frame = 1'b0; ev_ucast_pass = 1'b0;
  endtask

  task automatic t_reset();
    chk_reg("R1 reg", 32'h0);
    chk(filt_ptr == 3'd0, "R1 ptr", 32'(filt_ptr), 0);
    chk(!drop_frames && !pm_irq, "R1 outs", {drop_frames, pm_irq}, 0);
  endtask

  task automatic t_fields();
    wr(32'h7FFF_FFFE);
    chk_reg("R2 R5 reserved ignored, controls kept", 32'h0000_0206);
    chk(!drop_frames, "R5 drop low", 32'(drop_frames), 0);
    wr(32'h0000_0001);
    chk(drop_frames, "R5 drop follows bit0", 32'(drop_frames), 1);
    wr(32'h0);
  endtask

  task automatic t_ptr();
    @(negedge clk); filt_access = 1'b1;
    repeat (10) @(negedge clk);
    filt_access = 1'b0;
    #1 chk(filt_ptr == 3'd2, "R4 wrap after 10", 32'(filt_ptr), 2);
    wr(32'h8000_0000);
    chk_reg("R3 bit31 visible one cycle", 32'h8000_0000);
    chk(filt_ptr == 3'd2, "R3 ptr before reset", 32'(filt_ptr), 2);
    @(negedge clk);
    chk_reg("R3 bit31 self-cleared", 32'h0);
    chk(filt_ptr == 3'd0, "R3 ptr reset", 32'(filt_ptr), 0);
    @(negedge clk); filt_access = 1'b1;
    @(negedge clk); filt_access = 1'b0;
    wr(32'h8000_0000);
    filt_access = 1'b1;
    @(negedge clk); filt_access = 1'b0;
    #1 chk(filt_ptr == 3'd0, "R4 reset beats advance", 32'(filt_ptr), 0);
  endtask

  task automatic t_magic();
    wr(32'h3);
    chk(drop_frames, "R5 armed", 32'(drop_frames), 1);
    pulse(1'b1, 1'b0, 1'b0);
    #1 chk(!drop_frames, "R6 pd cleared", 32'(drop_frames), 0);
    chk(pm_irq, "R11 irq high", 32'(pm_irq), 1);
    rd("R6 status bit5", 32'h22);
    #1 chk(!pm_irq, "R10 R11 read clears", 32'(pm_irq), 0);
    chk_reg("R10 bit5 gone", 32'h2);
  endtask

  task automatic t_wframe();
    wr(32'h5);
    pulse(1'b0, 1'b1, 1'b0);
    #1 chk(!drop_frames && pm_irq, "R7 wake frame", {drop_frames, pm_irq}, 32'h1);
    rd("R7 status bit6", 32'h44);
  endtask

  task automatic t_ucast();
    wr(32'h5);
    pulse(1'b0, 1'b0, 1'b1);
    chk_reg("R8 ucast ignored without bit9", 32'h5);
    wr(32'h205);
    pulse(1'b0, 1'b0, 1'b1);
    rd("R8 ucast wakes with bit9", 32'h244);
  endtask

  task automatic t_disabled();
    wr(32'h1);
    pulse(1'b1, 1'b1, 1'b1);
    chk_reg("R9 enables clear", 32'h1);
    chk(!pm_irq, "R9 no irq", 32'(pm_irq), 0);
    wr(32'h6);
    pulse(1'b1, 1'b1, 1'b0);
    chk_reg("R9 pd clear ignores events", 32'h6);
    chk(!pm_irq, "R9 no irq awake", 32'(pm_irq), 0);
  endtask

  task automatic t_race();
    wr(32'h3);
    @(negedge clk); reg_re = 1'b1; ev_magic = 1'b1;
    #1 chk(reg_rdata === 32'h3, "R10 read returns old", reg_rdata, 32'h3);
    @(negedge clk); reg_re = 1'b0; ev_magic = 1'b0;
    chk_reg("R10 flag survives race", 32'h22);
    wr(32'h62);
    chk_reg("R10 write keeps status", 32'h22);
    wr(32'h2);
    chk_reg("R10 write cannot clear status", 32'h22);
    rd("R10 final read", 32'h22);
    chk_reg("R10 cleared", 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_ptr();
    t_magic();
    t_wframe();
    t_ucast();
    t_disabled();
    t_race();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule